// File: doc/BRIEF.md
# Prioritized Interrupt Vector Register

This block merges the pending-event flags of six capture/compare channels (numbered 1 to 6) and one counter-overflow source into a single interrupt request. It also presents a read-only vector word that identifies the most urgent enabled source. The vector value is always an even number, so software can add it straight to its program counter and land in a table of two-byte jump instructions. A value of zero means that nothing enabled is pending.

Each read of the vector word clears only the flag whose code was returned. Every other flag stays latched, so a handler can loop on reads and service each source in turn. Channel 0 does not take part in the shared vector. It has its own flag and its own request line, and its flag drops when that request is acknowledged. The timer counter and the compare logic sit outside this block and deliver single-cycle set pulses.

Top module: `irq_vector_unit`

## Requirements
- R1: While `rst_ni` is low, and after it is released, all flags are clear: `vec_o` reads 0 and both `irq_shared_o` and `irq_ch0_o` are low.
- R2: The vector code for channel k (1..6) is 2·k, so the values run 2, 4, 6, 8, 10 and 12. An overflow gives 14 and no enabled pending source gives 0. Bit 0 of `vec_o` is always 0. On `set_ch_i`, bit k-1 belongs to channel k.
- R3: Priority is fixed. Channel 1 is the highest and the channels follow in rising number, with overflow the lowest.
- R4: A cycle with `rd_vec_i` high clears only the flag encoded in `vec_o` during that cycle. The next cycle shows the code of the next pending enabled source.
- R5: A flag whose enable is low stays latched. It is not encoded and a read does not clear it. Raising its enable later makes it visible.
- R6: `irq_shared_o` is high exactly when at least one enabled flag among channels 1..6 and overflow is set.
- R7: Channel 0 never appears in `vec_o`. `irq_ch0_o` is its flag ANDed with `en_ch0_i`, and `ack_ch0_i` clears that flag.
- R8: When a set pulse and a clear (a read or an acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R9: A read while `vec_o` is 0 changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| set_ch_i | input | 6 | Set pulses for channels 1..6 (bit 0 = channel 1) |
| set_ovf_i | input | 1 | Set pulse for the overflow flag |
| set_ch0_i | input | 1 | Set pulse for the channel-0 flag |
| en_ch_i | input | 6 | Enables for channels 1..6 |
| en_ovf_i | input | 1 | Enable for overflow |
| en_ch0_i | input | 1 | Enable for channel 0 |
| rd_vec_i | input | 1 | Vector-word read strobe (read-to-clear) |
| ack_ch0_i | input | 1 | Channel-0 interrupt acknowledge |
| vec_o | output | 16 | Vector word: an even code of the winning source |
| irq_shared_o | output | 1 | Request for channels 1..6 and overflow |
| irq_ch0_o | output | 1 | Request for channel 0 |

## Verification
A set pulse and a read-to-clear can land on the same flag in the same cycle. The same holds for the channel-0 set and its acknowledge. The bench provokes both by raising the set pulse in the cycle where the read or the acknowledge targets that flag. A reference model then requires the flag to stay pending, so the following cycles must still show its code or its request. A read that coincides with a set on a different, lower-priority flag is also driven, and it must clear only the flag that was winning.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  // Jump-table offset for source index (0 = channel 1)
  function automatic int unsigned src_code(int unsigned idx);
    return 2 * (idx + 1);
  endfunction
endpackage

// File: rtl/irqv_flag_bank.sv
module irqv_flag_bank #(
  parameter int unsigned NUM_SRC = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] flags_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flags_o[g] <= 1'b0;
      else if (set_i[g])  flags_o[g] <= 1'b1;  // set beats clear
      else if (clr_i[g])  flags_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/irqv_prio_enc.sv
module irqv_prio_enc
  import irqv_pkg::*;
#(
  parameter int unsigned NUM_SRC = 7,
  parameter int unsigned VEC_W   = 16
) (
  input  logic [NUM_SRC-1:0] act_i,
  output logic [NUM_SRC-1:0] grant_o,
  output logic [VEC_W-1:0]   vec_o
);
  always_comb begin
    grant_o = '0;
    vec_o   = '0;
    // Walk downward so the lowest index is the last to be written
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (act_i[k]) begin
        grant_o = NUM_SRC'(1) << k;
        vec_o   = VEC_W'(src_code(k));
      end
    end
  end
endmodule

// File: rtl/irqv_ch0.sv
module irqv_ch0 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  input  logic en_i,
  output logic irq_o
);
  logic flag_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (ack_i) flag_q <= 1'b0;
  end
  assign irq_o = flag_q & en_i;
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit #(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned VEC_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] set_ch_i,
  input  logic              set_ovf_i,
  input  logic              set_ch0_i,
  input  logic [NUM_CH-1:0] en_ch_i,
  input  logic              en_ovf_i,
  input  logic              en_ch0_i,
  input  logic              rd_vec_i,
  input  logic              ack_ch0_i,
  output logic [VEC_W-1:0]  vec_o,
  output logic              irq_shared_o,
  output logic              irq_ch0_o
);
  localparam int unsigned NUM_SRC = NUM_CH + 1;

  logic [NUM_SRC-1:0] set_src, en_src, flags_q, act, grant, clr_src;

  assign set_src = {set_ovf_i, set_ch_i};
  assign en_src  = {en_ovf_i, en_ch_i};
  assign act     = flags_q & en_src;
  assign clr_src = rd_vec_i ? grant : '0;

  irqv_flag_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_src),
    .clr_i   (clr_src),
    .flags_o (flags_q)
  );

  irqv_prio_enc #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_enc (
    .act_i   (act),
    .grant_o (grant),
    .vec_o   (vec_o)
  );

  assign irq_shared_o = |act;

  irqv_ch0 u_ch0 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_ch0_i),
    .ack_i  (ack_ch0_i),
    .en_i   (en_ch0_i),
    .irq_o  (irq_ch0_o)
  );
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned VEC_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH:0]   flags_q,
  input logic [NUM_CH:0]   set_src,
  input logic [NUM_CH:0]   en_src,
  input logic              rd_vec_i,
  input logic              set_ch0_i,
  input logic              ack_ch0_i,
  input logic [VEC_W-1:0]  vec_o,
  input logic              irq_shared_o,
  input logic              irq_ch0_o
);
  a_r2_even_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_o[0] && vec_o <= VEC_W'(2 * (NUM_CH + 1)));

  a_r6_irq_matches_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_shared_o == (vec_o != '0));

  a_r4_one_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vec_i |=> $countones($past(flags_q) & ~flags_q) <= 1);

  a_r5_disabled_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vec_i |=> ($past(flags_q) & ~$past(en_src) & ~flags_q) == '0);

  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_src != '0) |=> (flags_q & $past(set_src)) == $past(set_src));

  a_r9_idle_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_vec_i && vec_o == '0) |=> flags_q == ($past(flags_q) | $past(set_src)));

  a_r7_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_ch0_i && !set_ch0_i) |=> !irq_ch0_o);
endmodule

bind irq_vector_unit irqv_checker #(.NUM_CH(NUM_CH), .VEC_W(VEC_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .flags_q      (flags_q),
  .set_src      (set_src),
  .en_src       (en_src),
  .rd_vec_i     (rd_vec_i),
  .set_ch0_i    (set_ch0_i),
  .ack_ch0_i    (ack_ch0_i),
  .vec_o        (vec_o),
  .irq_shared_o (irq_shared_o),
  .irq_ch0_o    (irq_ch0_o)
);

// File: tb/irq_vector_unit_test.sv
module irq_vector_unit_test;
  localparam int NCH = 6;

  logic clk_i = 0, rst_ni = 0;
  logic [NCH-1:0] set_ch_i = '0, en_ch_i = '0;
  logic set_ovf_i = 0, set_ch0_i = 0, en_ovf_i = 0, en_ch0_i = 0;
  logic rd_vec_i = 0, ack_ch0_i = 0;
  logic [15:0] vec_o;
  logic irq_shared_o, irq_ch0_o;

  int total = 0, bad = 0;
  string cur_req = "R1";
  bit done = 0;

  // reference state: index 0..5 = channels 1..6, 6 = overflow
  bit ref_flag [7];
  bit ref_ch0;

  irq_vector_unit uut (.*);

  always #5 clk_i = ~clk_i;

  function automatic int exp_vec();
    for (int k = 0; k < 7; k++) begin
      bit en = (k == 6) ? en_ovf_i : en_ch_i[k];
      if (ref_flag[k] && en) return 2 * (k + 1);
    end
    return 0;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < 7; k++) ref_flag[k] <= 0;
      ref_ch0 <= 0;
    end else begin
      automatic int v = exp_vec();
      automatic bit nxt [7];
      for (int k = 0; k < 7; k++) nxt[k] = ref_flag[k];
      if (rd_vec_i && v != 0) nxt[v/2 - 1] = 0;
      for (int k = 0; k < 6; k++) if (set_ch_i[k]) nxt[k] = 1;
      if (set_ovf_i) nxt[6] = 1;
      for (int k = 0; k < 7; k++) ref_flag[k] <= nxt[k];
      if (set_ch0_i) ref_ch0 <= 1;
      else if (ack_ch0_i) ref_ch0 <= 0;
    end
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (!done) begin
      automatic int v = exp_vec();
      check({cur_req, " vec"}, int'(vec_o), v);
      check({cur_req, " R6 irq_shared"}, int'(irq_shared_o), int'(v != 0));
      check({cur_req, " R7 irq_ch0"}, int'(irq_ch0_o), int'(ref_ch0 && en_ch0_i));
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk_i); #1; end
  endtask

  task automatic clear_pulses();
    set_ch_i = '0; set_ovf_i = 0; set_ch0_i = 0; rd_vec_i = 0; ack_ch0_i = 0;
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cur_req = "R1";
    en_ch_i = '1; en_ovf_i = 1; en_ch0_i = 1;
    tick(3);
    rst_ni = 1;
    tick(2);

    // R2: each source alone, then read it away
    cur_req = "R2";
    for (int k = 0; k < 6; k++) begin
      set_ch_i[k] = 1; tick; clear_pulses(); tick;
      rd_vec_i = 1; tick; clear_pulses(); tick;
    end
    set_ovf_i = 1; tick; clear_pulses(); tick;
    rd_vec_i = 1; tick; clear_pulses(); tick;

    // R3 and R4: all pending, drain by successive reads
    cur_req = "R3";
    set_ch_i = '1; set_ovf_i = 1; tick; clear_pulses(); tick;
    cur_req = "R4";
    for (int k = 0; k < 8; k++) begin rd_vec_i = 1; tick; end
    clear_pulses(); tick;

    // R4: read plus a lower-priority set in the same cycle
    set_ch_i = 6'b000100; tick; clear_pulses();
    rd_vec_i = 1; set_ch_i = 6'b100000; tick; clear_pulses(); tick;
    rd_vec_i = 1; tick; clear_pulses(); tick;

    // R5: disabled flags stay latched and are skipped
    cur_req = "R5";
    en_ch_i = 6'b111101;
    set_ch_i = 6'b001010; tick; clear_pulses(); tick;
    rd_vec_i = 1; tick; clear_pulses(); tick;
    rd_vec_i = 1; tick; clear_pulses(); tick;
    en_ch_i = '1; tick(2);
    rd_vec_i = 1; tick; clear_pulses(); tick;
    en_ovf_i = 0; set_ovf_i = 1; tick; clear_pulses();
    rd_vec_i = 1; tick; clear_pulses();
    en_ovf_i = 1; tick(2);
    rd_vec_i = 1; tick; clear_pulses(); tick;

    // R6: request follows enable of a pending flag
    cur_req = "R6";
    set_ch_i = 6'b010000; tick; clear_pulses();
    en_ch_i = '0; tick(2); en_ch_i = '1; tick;
    rd_vec_i = 1; tick; clear_pulses(); tick;

    // R7: channel 0 separate line, enable gating, acknowledge
    cur_req = "R7";
    set_ch0_i = 1; tick; clear_pulses(); tick;
    en_ch0_i = 0; tick; en_ch0_i = 1; tick;
    rd_vec_i = 1; tick; clear_pulses();
    ack_ch0_i = 1; tick; clear_pulses(); tick;

    // R8: set and clear on the same flag in one cycle
    cur_req = "R8";
    set_ch_i = 6'b000010; tick; clear_pulses();
    rd_vec_i = 1; set_ch_i = 6'b000010; tick; clear_pulses(); tick;
    rd_vec_i = 1; tick; clear_pulses(); tick;
    set_ch0_i = 1; tick;
    ack_ch0_i = 1; tick; clear_pulses(); tick;
    ack_ch0_i = 1; tick; clear_pulses(); tick;

    // R9: read with nothing visible
    cur_req = "R9";
    en_ch_i = 6'b111110;
    set_ch_i = 6'b000001; tick; clear_pulses();
    rd_vec_i = 1; tick(2); clear_pulses();
    en_ch_i = '1; tick(2);
    rd_vec_i = 1; tick; clear_pulses(); tick(2);

    // R1: reset again with flags pending
    cur_req = "R1";
    set_ch_i = '1; set_ovf_i = 1; set_ch0_i = 1; tick; clear_pulses();
    #2 rst_ni = 0; tick(2);
    rst_ni = 1; tick(2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule